// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block models a synchronous, pipelined, common-I/O static RAM. Reads and writes may follow one another on consecutive clock edges in any mix, with no idle cycle at a read-to-write or write-to-read change. A read returns data one edge after its address is sampled. A write takes its data from the bus two edges after its address. So the data slot of a write always lands where a read would otherwise have driven, and the bus never needs a turnaround cycle.

The external bidirectional bus is split into `dq_in`, `dq_out` and `dq_oe`. Each lane of `LANE_W` bits carries one data byte and its parity bit. A two-bit burst counter steps the low address bits in linear or interleaved order. A per-lane write mask and forwarding from the pending write slot keep reads coherent. A clock-enable pin can stall the whole pipeline. A sleep input deselects the device after a two-edge delay.

Top module: `psram_top`

## Requirements
- R1: A new access is sampled on a rising edge when `clk_en_n`=0, `adv_ld`=0, `ce1_n`=0, `ce2`=1 and `ce3_n`=0; `we_n`=0 makes it a write and `we_n`=1 a read; with any chip enable inactive no access starts.
- R2: When `clk_en_n`=1 the edge is ignored: pipeline stages, burst state, `dq_out` and the registered drive state all hold.
- R3: Data of a read sampled at edge n appears on `dq_out` after edge n+1, and `dq_oe` is 1 only while `oe_n`=0 (`oe_n` acts without a clock).
- R4: Write data for an address sampled at edge n is taken from `dq_in` at edge n+2, and `dq_oe` stays 0 through that data slot whatever `oe_n` is.
- R5: Lane k is bits [LANE_W*k+LANE_W-1 : LANE_W*k] (byte plus parity in the top bit); `bw_n[k]`=0 writes lane k, other lanes keep their contents, and a write with all `bw_n` high changes nothing.
- R6: With `adv_ld`=1 and `clk_en_n`=0 after a started access, the counter advances one beat; chip enables and `we_n` are ignored on that edge and the burst keeps the type captured at its start.
- R7: `burst_ilv`=1 gives beat address low bits = start XOR count; `burst_ilv`=0 gives start + count modulo 4; upper address bits stay those of the start.
- R8: After reset and after a deselecting edge, `dq_oe` is 0 from the following edge on; deselection is pipelined, so a read sampled just before still drives its data.
- R9: A read of the address whose write data is being taken on the same edge returns the new lanes merged over the array contents.
- R10: `sleep`=1 for two edges deselects the device, clears pending accesses and forces `dq_oe` to 0; array contents survive and normal accesses resume two edges after `sleep` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable at burst start, active low |
| adv_ld | input | 1 | 1 advances the burst, 0 loads an address |
| bw_n | input | N_LANES | Per-lane write selects, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low, unclocked |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address |
| dq_in | input | N_LANES*LANE_W | Bus data into the device |
| dq_out | output | N_LANES*LANE_W | Bus data driven by the device |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The core path is run with a table of single accesses in which writes and reads alternate every edge. The table includes full, partial and empty lane masks, and it reads back the same address on the edge where that write's data arrives. This separates correct lane masking from whole-word writes, and forwarding from a stale array read. Bursts are written in linear order and read back in both orders from different start points, so a wrong order, a wrong wrap or a lost write type shows up as specific wrong words. Directed cases cover stalls placed both before and after read data is launched, output enable toggled without a clock edge, pipelined deselection, and sleep entry and exit with stored data read back afterwards.

// File: rtl/psram_pkg.sv
package psram_pkg;
  // Low two address bits of a burst beat from its start offset and beat count
  function automatic logic [1:0] beat_ofs(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/psram_burst.sv
module psram_burst
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sleep_on,
  input  logic              sel,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_v,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              wr_q;
  logic              live_q;
  logic              start, step;
  logic [1:0]        cnt_nx;

  assign start  = en && !sleep_on && !adv_ld && sel;
  assign step   = en && !sleep_on && adv_ld && live_q;
  assign cnt_nx = cnt_q + 2'd1;

  always_comb begin
    acc_v    = start || step;
    acc_we   = start ? !we_n : wr_q;
    acc_addr = start ? addr
                     : {base_q[ADDR_W-1:2], beat_ofs(base_q[1:0], cnt_nx, burst_ilv)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      base_q <= '0;
    end else if (sleep_on) begin
      live_q <= 1'b0;
    end else if (start) begin
      base_q <= addr;
      cnt_q  <= '0;
      wr_q   <= !we_n;
      live_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_nx;
    end else if (en && !adv_ld) begin
      live_q <= 1'b0;
    end
  end

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) + 2'd1) && live_q);
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int ADDR_W  = 6,
  parameter int N_LANES = 4,
  parameter int LANE_W  = 9
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [N_LANES-1:0]        wmask,
  input  logic [N_LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [N_LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = N_LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < N_LANES; k++) begin
        if (wmask[k]) mem[waddr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/psram_out.sv
module psram_out #(
  parameter int N_LANES = 4,
  parameter int LANE_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      sleep_on,
  input  logic                      rd_v,
  input  logic [N_LANES*LANE_W-1:0] arr_word,
  input  logic                      fwd_hit,
  input  logic [N_LANES-1:0]        fwd_mask,
  input  logic [N_LANES*LANE_W-1:0] fwd_data,
  output logic [N_LANES*LANE_W-1:0] out_q,
  output logic                      drive_q
);
  localparam int DW = N_LANES * LANE_W;
  logic [DW-1:0] merged;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && fwd_mask[g])
                                        ? fwd_data[g*LANE_W +: LANE_W]
                                        : arr_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      out_q   <= '0;
    end else if (sleep_on) begin
      drive_q <= 1'b0;
    end else if (en) begin
      drive_q <= rd_v;
      if (rd_v) out_q <= merged;
    end
  end

  // R8
  no_read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rd_v) |=> !drive_q);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sleep_on) |=> $stable(out_q) && $stable(drive_q));
endmodule

// File: rtl/psram_top.sv
module psram_top #(
  parameter int ADDR_W  = 6,
  parameter int N_LANES = 4,
  parameter int LANE_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_n,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      we_n,
  input  logic                      adv_ld,
  input  logic [N_LANES-1:0]        bw_n,
  input  logic                      burst_ilv,
  input  logic                      oe_n,
  input  logic                      sleep,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [N_LANES*LANE_W-1:0] dq_in,
  output logic [N_LANES*LANE_W-1:0] dq_out,
  output logic                      dq_oe
);
  localparam int DW = N_LANES * LANE_W;

  logic              en, sel, sleep_on;
  logic [1:0]        sleep_q;
  logic              acc_v, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic              s1_v, s1_we, s2_v;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [N_LANES-1:0] s1_bw, s2_bw;
  logic [DW-1:0]     arr_word, out_q;
  logic              drive_q;

  assign en       = !clk_en_n;
  assign sel      = !ce1_n && ce2 && !ce3_n;
  assign sleep_on = sleep_q[1];

  // two-edge sleep entry/exit delay, independent of clock enable
  always_ff @(posedge clk) begin
    if (!rst_n) sleep_q <= '0;
    else        sleep_q <= {sleep_q[0], sleep};
  end

  psram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(en), .sleep_on(sleep_on), .sel(sel),
    .adv_ld(adv_ld), .we_n(we_n), .burst_ilv(burst_ilv), .addr(addr),
    .acc_v(acc_v), .acc_we(acc_we), .acc_addr(acc_addr)
  );

  // address stage (s1) and late-write data stage (s2)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_we <= 1'b0; s1_addr <= '0; s1_bw <= '0;
      s2_v <= 1'b0; s2_addr <= '0; s2_bw <= '0;
    end else if (sleep_on) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (en) begin
      s1_v    <= acc_v;
      s1_we   <= acc_we;
      s1_addr <= acc_addr;
      s1_bw   <= ~bw_n;
      s2_v    <= s1_v && s1_we;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
    end
  end

  psram_array #(.ADDR_W(ADDR_W), .N_LANES(N_LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(en && s2_v && !sleep_on), .waddr(s2_addr), .wmask(s2_bw),
    .wdata(dq_in), .raddr(s1_addr), .rdata(arr_word)
  );

  psram_out #(.N_LANES(N_LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .sleep_on(sleep_on),
    .rd_v(s1_v && !s1_we), .arr_word(arr_word),
    .fwd_hit(s2_v && (s2_addr == s1_addr)), .fwd_mask(s2_bw), .fwd_data(dq_in),
    .out_q(out_q), .drive_q(drive_q)
  );

  assign dq_out = out_q;
  assign dq_oe  = drive_q && !oe_n && !sleep_on;

  // R4
  write_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |-> !dq_oe);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_on |=> !dq_oe && !s1_v);
endmodule

// File: tb/tb_psram_top.sv
module tb_psram_top;
  localparam int AW = 6, NL = 4, LW = 9, DW = NL * LW;
  localparam int NOPS = 15;
  // {is_write, bw_n, addr, data}
  localparam logic [46:0] OPS [NOPS] = '{
    {1'b1, 4'h0, 6'd1, 36'h0A1B2C3D4},
    {1'b1, 4'h0, 6'd2, 36'h955AA33CC},
    {1'b0, 4'hF, 6'd1, 36'h0},
    {1'b1, 4'h0, 6'd3, 36'hFEDCBA987},
    {1'b0, 4'hF, 6'd2, 36'h0},
    {1'b1, 4'hA, 6'd1, 36'h111111111},
    {1'b0, 4'hF, 6'd1, 36'h0},
    {1'b1, 4'hF, 6'd2, 36'h000000000},
    {1'b0, 4'hF, 6'd3, 36'h0},
    {1'b0, 4'hF, 6'd2, 36'h0},
    {1'b1, 4'h7, 6'd3, 36'hABCDEF012},
    {1'b0, 4'hF, 6'd3, 36'h0},
    {1'b0, 4'hF, 6'd1, 36'h0},
    {1'b1, 4'h0, 6'd4, 36'h5A5A5A5A5},
    {1'b0, 4'hF, 6'd4, 36'h0}
  };
  localparam logic [35:0] BD [4] = '{36'h100000001, 36'h200000002, 36'h300000003, 36'h400000004};

  logic clk = 0, rst_n = 0, clk_en_n = 0, ce1_n = 1, ce2 = 1, ce3_n = 0;
  logic we_n = 1, adv_ld = 0, burst_ilv = 0, oe_n = 0, sleep = 0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;
  logic [DW-1:0] ref_mem [1 << AW];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  psram_top #(.ADDR_W(AW), .N_LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .we_n(we_n), .adv_ld(adv_ld), .bw_n(bw_n),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic idle();
    ce1_n = 1; adv_ld = 0; we_n = 1; bw_n = '1; clk_en_n = 0;
  endtask

  task automatic begin_acc(input logic wr, input logic [AW-1:0] a, input logic [NL-1:0] m);
    ce1_n = 0; adv_ld = 0; we_n = !wr; addr = a; bw_n = m;
  endtask

  // chip enables deliberately inactive and we_n flipped: must be ignored (R6)
  task automatic advance();
    adv_ld = 1; ce1_n = 1; we_n = ~we_n; bw_n = '0;
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R8: reset state
    chk("R8 reset three-state", {35'd0, dq_oe}, '0);
    rst_n = 1;
    tick();
    chk("R8 idle after reset", {35'd0, dq_oe}, '0);

    // table: alternating reads and writes, no idle cycles (R1 R3 R4 R5 R9)
    for (int k = 0; k < NOPS + 2; k++) begin
      if (k < NOPS) begin
        begin_acc(OPS[k][46], OPS[k][41:36], OPS[k][45:42]);
      end else idle();
      if (k >= 2 && OPS[k-2][46]) dq_in = OPS[k-2][35:0];
      tick();
      if (k >= 2 && OPS[k-2][46]) begin
        for (int j = 0; j < NL; j++)
          if (!OPS[k-2][42+j]) ref_mem[OPS[k-2][41:36]][j*LW +: LW] = OPS[k-2][j*LW +: LW];
      end
      if (k >= 1 && k - 1 < NOPS) begin
        if (OPS[k-1][46]) chk("R4 write slot not driven", {35'd0, dq_oe}, '0);
        else begin
          chk("R3 read drives bus", {35'd0, dq_oe}, 36'd1);
          chk("R5/R9 read data", dq_out, ref_mem[OPS[k-1][41:36]]);
        end
      end
    end

    // R1: chip enable inactive (ce2 low) -> no access, nothing driven
    ce2 = 0; begin_acc(0, 6'd1, '1); tick(); idle(); ce2 = 1; tick();
    chk("R1 deselected read ignored", {35'd0, dq_oe}, '0);

    // burst write, linear from 8 (R6 R7)
    burst_ilv = 0;
    begin_acc(1, 6'd8, '0); tick();
    advance(); tick();
    advance(); dq_in = BD[0]; tick();
    advance(); dq_in = BD[1]; tick();
    idle(); dq_in = BD[2]; tick();
    dq_in = BD[3]; tick();
    dq_in = '0;

    // burst read interleaved from 10: 10,11,8,9
    burst_ilv = 1;
    begin_acc(0, 6'd10, '1); tick();
    advance(); tick(); chk("R7 interleaved beat0", dq_out, BD[2]);
    advance(); tick(); chk("R7 interleaved beat1", dq_out, BD[3]);
    advance(); tick(); chk("R7 interleaved beat2", dq_out, BD[0]);
    idle(); tick();
    chk("R6 burst kept read type", dq_out, BD[1]);
    chk("R8 pipelined deselect still drives", {35'd0, dq_oe}, 36'd1);
    tick();
    chk("R8 three-state after deselect", {35'd0, dq_oe}, '0);

    // burst read linear from 9: 9,10,11,8
    burst_ilv = 0;
    begin_acc(0, 6'd9, '1); tick();
    advance(); tick(); chk("R7 linear beat0", dq_out, BD[1]);
    advance(); tick(); chk("R7 linear beat1", dq_out, BD[2]);
    advance(); tick(); chk("R7 linear beat2", dq_out, BD[3]);
    idle(); tick(); chk("R7 linear wrap beat3", dq_out, BD[0]);
    tick();

    // R2: stall before and after data launch
    begin_acc(0, 6'd8, '1); tick();
    clk_en_n = 1; ce1_n = 1; tick();
    chk("R2 stall holds launch", {35'd0, dq_oe}, '0);
    idle(); tick();
    chk("R2 data after stall", dq_out, BD[0]);
    clk_en_n = 1; begin_acc(0, 6'd9, '1); clk_en_n = 1; tick();
    chk("R2 stall holds output", dq_out, BD[0]);
    chk("R2 stall holds drive", {35'd0, dq_oe}, 36'd1);
    idle(); tick(); tick();

    // R3: output enable acts without a clock
    oe_n = 1; begin_acc(0, 6'd11, '1); tick(); idle(); tick();
    chk("R3 oe_n high no drive", {35'd0, dq_oe}, '0);
    oe_n = 0; #1;
    chk("R3 oe_n low drives", {35'd0, dq_oe}, 36'd1);
    chk("R3 data under oe", dq_out, BD[3]);
    tick();

    // R10: sleep
    sleep = 1; tick(); tick();
    begin_acc(0, 6'd8, '1); tick(); idle(); tick();
    chk("R10 sleep blocks access", {35'd0, dq_oe}, '0);
    sleep = 0; tick(); tick();
    begin_acc(0, 6'd8, '1); tick(); idle(); tick();
    chk("R10 contents kept after sleep", dq_out, BD[0]);
    chk("R10 drive resumes", {35'd0, dq_oe}, 36'd1);
    tick();

    report();
    $finish;
  end
endmodule